// File: doc/BRIEF.md
# Two-Queue Weighted Round-Robin Egress Scheduler

This block decides, for one switch port, which of two egress queues (high priority and low priority) sends the next frame. The queues themselves and the frame data path sit outside; the scheduler sees only a non-empty flag per queue, a one-cycle pulse from the transmitter when a frame has been fully sent, and a 2-bit ratio select. It drives a registered grant that names at most one queue and changes only at frame boundaries.

Service is counted in whole frames. A credit counter allows a number of high-queue frames before one low-queue frame is due. The ratio select picks 2, 4 or 8 high frames per low frame, or strict priority. The scheduler is work-conserving: if the queue that is due is empty, the other queue is served at once and no credit is spent.

A small combinational classifier sits beside the scheduler. It marks an incoming frame high priority when any enabled source says so. The sources are a per-port flag, the 3-bit VLAN priority code and the 6-bit DS codepoint.

Top module: `wrr_egress_sched`

## Requirements
- R1: Out of reset no grant is active, and at most one of `grant_hi`/`grant_lo` is ever high.
- R2: While no grant is active and at least one queue is non-empty, a grant is active on the next clock edge.
- R3: An active grant does not change until a cycle with `pkt_done` high; the new grant appears on the clock edge that samples `pkt_done`.
- R4: With both queues backlogged, `ratio_sel` 2'b00, 2'b01 and 2'b10 give repeating patterns of 2, 4 and 8 high-queue frames, each followed by one low-queue frame. The first grant after idle goes to the high queue.
- R5: With `ratio_sel` = 2'b11, the low queue is granted only when the high queue is empty.
- R6: If the queue that is due is empty, the other non-empty queue is granted immediately. A low-queue frame sent this way refills the high credit.
- R7: While the low queue is empty, the high credit is held at the full weight. When the low queue then fills, the high queue gets the full weight of frames before the low queue is served.
- R8: When both queues are empty at a decision point, no grant is given. A `pkt_done` pulse while no grant is active has no effect.
- R9: `cls_high` is the OR of three terms: `port_pri_en & port_pri_hi`, `pcp_en & (pcp >= 4)`, and `ds_en & (dscp >= 40)`.
- R10: A classification source whose enable is low has no effect on `cls_high`, whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_nonempty | input | 1 | High queue holds at least one frame |
| lo_nonempty | input | 1 | Low queue holds at least one frame |
| pkt_done | input | 1 | One-cycle pulse: granted frame finished |
| ratio_sel | input | 2 | 00=2:1, 01=4:1, 10=8:1, 11=strict |
| grant_hi | output | 1 | High queue may send the next frame |
| grant_lo | output | 1 | Low queue may send the next frame |
| port_pri_en | input | 1 | Enable port-based classification |
| port_pri_hi | input | 1 | Port is configured high priority |
| pcp_en | input | 1 | Enable VLAN priority-code classification |
| pcp | input | 3 | Frame's VLAN priority code |
| ds_en | input | 1 | Enable DS-codepoint classification |
| dscp | input | 6 | Frame's DS codepoint |
| cls_high | output | 1 | Frame belongs in the high queue |

## Verification
Each ratio setting is run with both queues backlogged for nine frames. Only the grant sequence separates the 2, 4 and 8 weights and strict mode. Runs with a single non-empty queue and with none show that the scheduler conserves work and does not grant from empty queues. Directed cases empty one queue partway through a cycle: emptying the high queue while it is due shows that no credit is spent, and a brief gap in the low queue shows that the credit refills. Classifier inputs are set with each source enabled alone, with sources disabled but asserting, and at the threshold values. This shows the OR merge and the masking done by each enable.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
    typedef enum logic [1:0] {
        GR_NONE = 2'b00,
        GR_HI   = 2'b01,
        GR_LO   = 2'b10
    } grant_e;
endpackage

// File: rtl/wrr_prio_classifier.sv
module wrr_prio_classifier #(
    parameter int PCP_W       = 3,
    parameter int DSCP_W      = 6,
    parameter int PCP_HI_MIN  = 4,
    parameter int DSCP_HI_MIN = 40
) (
    input  logic              port_en,
    input  logic              port_hi,
    input  logic              pcp_en,
    input  logic [PCP_W-1:0]  pcp,
    input  logic              ds_en,
    input  logic [DSCP_W-1:0] dscp,
    output logic              is_high
);
    localparam logic [PCP_W-1:0]  PCP_THR  = PCP_W'(PCP_HI_MIN);
    localparam logic [DSCP_W-1:0] DSCP_THR = DSCP_W'(DSCP_HI_MIN);

    logic hit_port, hit_pcp, hit_ds;

    always_comb begin
        hit_port = port_en & port_hi;
        hit_pcp  = pcp_en & (pcp >= PCP_THR);
        hit_ds   = ds_en & (dscp >= DSCP_THR);
        is_high  = hit_port | hit_pcp | hit_ds;
    end

    always_comb begin
        a_r10_disabled_quiet: assert (port_en || pcp_en || ds_en || !is_high);
    end
endmodule

// File: rtl/wrr_credit_ctr.sv
module wrr_credit_ctr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] weight,
    input  logic          reload,
    input  logic          dec,
    output logic [CW-1:0] credit_now
);
    typedef struct packed {
        logic [CW-1:0] credit;
    } cred_s;

    cred_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (reload)
            s_d.credit = weight;
        else if (dec && s_q.credit != '0)
            s_d.credit = s_q.credit - 1'b1;
        credit_now = s_d.credit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r7_reload_takes_weight: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> s_q.credit == $past(weight));
endmodule

// File: rtl/wrr_grant_sel.sv
module wrr_grant_sel
    import wrr_pkg::*;
(
    input  logic   strict,
    input  logic   due_hi,
    input  logic   hi_ne,
    input  logic   lo_ne,
    output grant_e pick
);
    always_comb begin
        pick = GR_NONE;
        if (strict || due_hi) begin
            if (hi_ne)      pick = GR_HI;
            else if (lo_ne) pick = GR_LO;
        end else begin
            if (lo_ne)      pick = GR_LO;
            else if (hi_ne) pick = GR_HI;
        end
    end

    always_comb begin
        a_r8_no_pick_from_empty: assert (!((pick == GR_HI && !hi_ne) || (pick == GR_LO && !lo_ne)));
    end
endmodule

// File: rtl/wrr_egress_sched.sv
module wrr_egress_sched
    import wrr_pkg::*;
#(
    parameter int W_SEL0      = 2,
    parameter int W_SEL1      = 4,
    parameter int W_SEL2      = 8,
    parameter int PCP_HI_MIN  = 4,
    parameter int DSCP_HI_MIN = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hi_nonempty,
    input  logic       lo_nonempty,
    input  logic       pkt_done,
    input  logic [1:0] ratio_sel,
    output logic       grant_hi,
    output logic       grant_lo,
    input  logic       port_pri_en,
    input  logic       port_pri_hi,
    input  logic       pcp_en,
    input  logic [2:0] pcp,
    input  logic       ds_en,
    input  logic [5:0] dscp,
    output logic       cls_high
);
    localparam int WMAX = (W_SEL2 > W_SEL1) ? ((W_SEL2 > W_SEL0) ? W_SEL2 : W_SEL0)
                                            : ((W_SEL1 > W_SEL0) ? W_SEL1 : W_SEL0);
    localparam int CW   = $clog2(WMAX + 1);

    typedef struct packed {
        grant_e grant;
    } sched_s;

    sched_s        s_d, s_q;
    logic [CW-1:0] weight;
    logic [CW-1:0] credit_now;
    logic          strict, idle, decide, reload, dec;
    grant_e        pick;

    always_comb begin
        strict = 1'b0;
        case (ratio_sel)
            2'b00:   weight = CW'(W_SEL0);
            2'b01:   weight = CW'(W_SEL1);
            2'b10:   weight = CW'(W_SEL2);
            default: begin
                weight = CW'(W_SEL2);
                strict = 1'b1;
            end
        endcase
        idle   = (s_q.grant == GR_NONE);
        decide = idle | pkt_done;
        reload = idle | !lo_nonempty | (pkt_done & (s_q.grant == GR_LO));
        dec    = pkt_done & (s_q.grant == GR_HI);
    end

    wrr_credit_ctr #(.CW(CW)) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .weight     (weight),
        .reload     (reload),
        .dec        (dec),
        .credit_now (credit_now)
    );

    wrr_grant_sel u_sel (
        .strict (strict),
        .due_hi (credit_now != '0),
        .hi_ne  (hi_nonempty),
        .lo_ne  (lo_nonempty),
        .pick   (pick)
    );

    always_comb begin
        s_d = s_q;
        if (decide) s_d.grant = pick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{grant: GR_NONE};
        else        s_q <= s_d;
    end

    assign grant_hi = (s_q.grant == GR_HI);
    assign grant_lo = (s_q.grant == GR_LO);

    wrr_prio_classifier #(
        .PCP_W(3), .DSCP_W(6), .PCP_HI_MIN(PCP_HI_MIN), .DSCP_HI_MIN(DSCP_HI_MIN)
    ) u_cls (
        .port_en (port_pri_en),
        .port_hi (port_pri_hi),
        .pcp_en  (pcp_en),
        .pcp     (pcp),
        .ds_en   (ds_en),
        .dscp    (dscp),
        .is_high (cls_high)
    );

    a_r1_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_hi, grant_lo}));
    a_r2_idle_grants: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_hi && !grant_lo && (hi_nonempty || lo_nonempty)) |=> (grant_hi || grant_lo));
    a_r3_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_hi || grant_lo) && !pkt_done) |=> ($stable(grant_hi) && $stable(grant_lo)));
    a_r5_strict_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_sel == 2'b11 && hi_nonempty && (pkt_done || (!grant_hi && !grant_lo))) |=> grant_hi);
    a_r8_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_hi && !grant_lo && !hi_nonempty && !lo_nonempty) |=> (!grant_hi && !grant_lo));
endmodule

// File: tb/tb_wrr_egress_sched.sv
module tb_wrr_egress_sched;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       hi_nonempty, lo_nonempty, pkt_done;
    logic [1:0] ratio_sel;
    logic       grant_hi, grant_lo;
    logic       port_pri_en, port_pri_hi, pcp_en, ds_en;
    logic [2:0] pcp;
    logic [5:0] dscp;
    logic       cls_high;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wrr_egress_sched dut (
        .clk(clk), .rst_n(rst_n), .hi_nonempty(hi_nonempty), .lo_nonempty(lo_nonempty),
        .pkt_done(pkt_done), .ratio_sel(ratio_sel), .grant_hi(grant_hi), .grant_lo(grant_lo),
        .port_pri_en(port_pri_en), .port_pri_hi(port_pri_hi), .pcp_en(pcp_en), .pcp(pcp),
        .ds_en(ds_en), .dscp(dscp), .cls_high(cls_high)
    );

    // {ratio[1:0], hi, lo, nine grant codes {lo,hi}, first in the MSBs}
    localparam int NV = 8;
    localparam logic [21:0] VEC [NV] = '{
        {2'b00, 1'b1, 1'b1, 18'b01_01_10_01_01_10_01_01_10},
        {2'b01, 1'b1, 1'b1, 18'b01_01_01_01_10_01_01_01_01},
        {2'b10, 1'b1, 1'b1, 18'b01_01_01_01_01_01_01_01_10},
        {2'b11, 1'b1, 1'b1, 18'b01_01_01_01_01_01_01_01_01},
        {2'b00, 1'b1, 1'b0, 18'b01_01_01_01_01_01_01_01_01},
        {2'b00, 1'b0, 1'b1, 18'b10_10_10_10_10_10_10_10_10},
        {2'b11, 1'b0, 1'b1, 18'b10_10_10_10_10_10_10_10_10},
        {2'b00, 1'b0, 1'b0, 18'b00_00_00_00_00_00_00_00_00}
    };
    localparam string VTAG [NV] = '{"R4", "R4", "R4", "R5", "R6", "R6", "R5", "R8"};

    task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pkt_done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse();
        @(negedge clk);
        pkt_done = 1'b1;
        @(negedge clk);
        pkt_done = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        hi_nonempty = 1'b0; lo_nonempty = 1'b0; pkt_done = 1'b0; ratio_sel = 2'b00;
        port_pri_en = 1'b0; port_pri_hi = 1'b0; pcp_en = 1'b0; ds_en = 1'b0;
        pcp = '0; dscp = '0;

        // R1: reset state with both queues backlogged
        hi_nonempty = 1'b1; lo_nonempty = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset", {grant_lo, grant_hi}, 2'b00);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            ratio_sel   = VEC[v][21:20];
            hi_nonempty = VEC[v][19];
            lo_nonempty = VEC[v][18];
            do_reset();
            @(negedge clk);
            for (int k = 0; k < 9; k++) begin
                chk(VTAG[v], {grant_lo, grant_hi}, VEC[v][17-2*k -: 2]);
                pulse();
            end
        end

        // R2/R3: grant arrives next cycle and holds without pkt_done
        ratio_sel = 2'b00; hi_nonempty = 1'b0; lo_nonempty = 1'b0;
        do_reset();
        @(negedge clk);
        lo_nonempty = 1'b1;
        @(negedge clk);
        chk("R2 idle to grant", {grant_lo, grant_hi}, 2'b10);
        hi_nonempty = 1'b1;
        repeat (5) @(negedge clk);
        chk("R3 hold", {grant_lo, grant_hi}, 2'b10);
        pulse();
        chk("R3 change at done", {grant_lo, grant_hi}, 2'b01);

        // R6: high due but empty -> low at once, then credit refilled
        ratio_sel = 2'b00; hi_nonempty = 1'b1; lo_nonempty = 1'b1;
        do_reset();
        @(negedge clk);
        chk("R6 start", {grant_lo, grant_hi}, 2'b01);
        hi_nonempty = 1'b0;
        pulse();
        chk("R6 low served", {grant_lo, grant_hi}, 2'b10);
        hi_nonempty = 1'b1;
        pulse();
        chk("R6 back to high", {grant_lo, grant_hi}, 2'b01);
        pulse();
        chk("R6 refilled credit", {grant_lo, grant_hi}, 2'b01);
        pulse();
        chk("R6 low after two", {grant_lo, grant_hi}, 2'b10);

        // R7: low queue gap refreshes high credit
        do_reset();
        @(negedge clk);
        pulse();
        chk("R7 second high", {grant_lo, grant_hi}, 2'b01);
        lo_nonempty = 1'b0;
        @(negedge clk);
        pulse();
        chk("R7 high while low empty", {grant_lo, grant_hi}, 2'b01);
        lo_nonempty = 1'b1;
        pulse();
        chk("R7 full weight after refill", {grant_lo, grant_hi}, 2'b01);
        pulse();
        chk("R7 low after full weight", {grant_lo, grant_hi}, 2'b10);

        // R8: pkt_done while idle has no effect
        hi_nonempty = 1'b0; lo_nonempty = 1'b0;
        pulse();
        chk("R8 drained", {grant_lo, grant_hi}, 2'b00);
        pulse();
        chk("R8 done while idle", {grant_lo, grant_hi}, 2'b00);

        // R9/R10: classifier
        port_pri_en = 1'b1; port_pri_hi = 1'b1; #1;
        chk("R9 port source", {1'b0, cls_high}, 2'b01);
        port_pri_en = 1'b0; #1;
        chk("R10 port disabled", {1'b0, cls_high}, 2'b00);
        port_pri_hi = 1'b0; pcp_en = 1'b1; pcp = 3'd3; #1;
        chk("R9 pcp below", {1'b0, cls_high}, 2'b00);
        pcp = 3'd4; #1;
        chk("R9 pcp at threshold", {1'b0, cls_high}, 2'b01);
        pcp_en = 1'b0; pcp = 3'd7; #1;
        chk("R10 pcp disabled", {1'b0, cls_high}, 2'b00);
        ds_en = 1'b1; dscp = 6'd39; #1;
        chk("R9 dscp below", {1'b0, cls_high}, 2'b00);
        dscp = 6'd40; #1;
        chk("R9 dscp at threshold", {1'b0, cls_high}, 2'b01);
        ds_en = 1'b0; dscp = 6'd63; port_pri_hi = 1'b1; #1;
        chk("R10 all disabled", {1'b0, cls_high}, 2'b00);
        pcp_en = 1'b1; pcp = 3'd1; ds_en = 1'b1; dscp = 6'd46; #1;
        chk("R9 OR merge", {1'b0, cls_high}, 2'b01);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule